// File: doc/BRIEF.md
# Region-Based Memory Access Guard

This block sits beside a bus master and judges every access it makes against a table of programmable address regions. An access presents an address, a kind (read, write or instruction fetch) and whether the master is running privileged. The block answers in the same cycle: `acc_fault` is high exactly when a valid access is refused. The first refused address is kept in a fault register until software clears it.

Each region holds a base, a size in bytes and a control word. The control word has an enable bit, three permission bits for privileged code, three for unprivileged code, and a memory-type field that is stored and read back but plays no part in the decision. The legality rule for region geometry is chosen at build time: either sizes are powers of two aligned to themselves, or sizes and bases only need 32-byte granularity. An enabled region that breaks the selected rule takes no part in matching and raises `cfg_err`.

Fault capture is a two-state machine. In state `FLT_EMPTY` no fault is held; the transition *capture* (a refused access) leads to `FLT_HELD` and loads the address. In `FLT_HELD` the transition *hold* (no clear) keeps the address fixed whatever happens on the bus, *release* (clear without a new fault) returns to `FLT_EMPTY`, and *recapture* (clear and a refused access in the same cycle) stays in `FLT_HELD` with the new address loaded.

Top module: `region_guard`

## Requirements
- R1: After reset every region's base, size and control word read back as zero, `flt_valid` is 0 and `cfg_err` is 0.
- R2: Control word layout: bit 0 enable, bit 1 privileged read, bit 2 privileged write, bit 3 privileged fetch, bit 4 unprivileged read, bit 5 unprivileged write, bit 6 unprivileged fetch, bits 8:7 memory type (0 normal, 1 device, 2 strongly-ordered). Access kind code 0 is read, 1 write, 2 fetch; for a matching address the access is allowed only when the bit for its kind and privilege level is set, and kind code 3 is always refused.
- R3: `acc_fault` is high in the same cycle as a valid access that is refused, and is low whenever `acc_valid` is low.
- R4: When several enabled, legal regions contain the address, the one with the highest index alone decides the outcome.
- R5: An address that hits no region is allowed for privileged access when `bg_allow` is 1, refused for privileged access when `bg_allow` is 0, and always refused for unprivileged access.
- R6: With `SIZE_MODE` 0 a region is legal only when its size is a power of two of at least 32 bytes and its base is a multiple of its size.
- R7: With `SIZE_MODE` 1 a region is legal when its size is a non-zero multiple of 32 and its base is a multiple of 32.
- R8: An enabled region that breaks the selected rule matches no address and sets `cfg_err`, which falls again once no enabled region is illegal.
- R9: The first refused access sets `flt_valid` on the next clock edge and loads its address into `flt_addr`.
- R10: While `flt_valid` is set, later refusals leave `flt_addr` unchanged; a `flt_clr` pulse clears `flt_valid`, unless a refusal occurs in that same cycle, in which case that new address is captured.
- R11: The memory-type field reads back as written and has no effect on any allow or refuse decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Region register write strobe |
| cfg_idx | input | IDXW | Region selected for write |
| cfg_sel | input | 2 | Field: 0 base, 1 size, 2 control, 3 none |
| cfg_wdata | input | AW | Write data |
| rd_idx | input | IDXW | Region selected for readback |
| rd_sel | input | 2 | Field selected for readback |
| rd_data | output | AW | Readback value |
| bg_allow | input | 1 | Background allow for privileged misses |
| acc_valid | input | 1 | Access present |
| acc_addr | input | AW | Access address |
| acc_type | input | 2 | Access kind |
| acc_priv | input | 1 | 1 for privileged access |
| acc_fault | output | 1 | Access refused, same cycle |
| flt_clr | input | 1 | Write-one-to-clear for the fault flag |
| flt_valid | output | 1 | Fault register holds an address |
| flt_addr | output | AW | First refused address |
| cfg_err | output | 1 | Some enabled region is illegal |

## Verification
The clear of the fault flag and the capture of a new refusal can land on the same clock edge. The bench provokes this by first holding a fault, then presenting a refused access in the very cycle `flt_clr` is pulsed, and judges it by requiring `flt_valid` to stay set with the new address rather than the old one or an empty register. The same edge is also exercised with a permitted access beside the clear, where the register must empty.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;

    localparam int CTRL_W   = 9;
    localparam int MIN_GRAN = 32;
    localparam int GRAN_LSB = $clog2(MIN_GRAN);

    typedef enum logic [1:0] {
        ACC_RD    = 2'd0,
        ACC_WR    = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [1:0] mtype;
        logic       ux;
        logic       uw;
        logic       ur;
        logic       px;
        logic       pw;
        logic       pr;
        logic       en;
    } rg_ctrl_t;

    typedef enum logic {
        FLT_EMPTY = 1'b0,
        FLT_HELD  = 1'b1
    } flt_state_e;

endpackage

// File: rtl/rg_region.sv
module rg_region
    import region_guard_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SIZE_MODE = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic          bad,
    output rg_ctrl_t      ctrl_o,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] size_o
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] size_q;
    rg_ctrl_t      ctrl_q;
    logic          legal;
    logic [AW-1:0] offset;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            size_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                2'd0:    base_q <= wr_data;
                2'd1:    size_q <= wr_data;
                2'd2:    ctrl_q <= rg_ctrl_t'(wr_data[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    generate
        if (SIZE_MODE == 0) begin : g_pow2
            logic [AW-1:0] mask;
            assign mask  = size_q - 1'b1;
            assign legal = (size_q >= AW'(MIN_GRAN))
                         && ((size_q & mask) == '0)
                         && ((base_q & mask) == '0);
        end else begin : g_gran
            assign legal = (size_q != '0)
                         && (size_q[GRAN_LSB-1:0] == '0)
                         && (base_q[GRAN_LSB-1:0] == '0);
        end
    endgenerate

    assign offset = addr - base_q;
    assign hit    = ctrl_q.en && legal && (addr >= base_q) && (offset < size_q);
    assign bad    = ctrl_q.en && !legal;
    assign ctrl_o = ctrl_q;
    assign base_o = base_q;
    assign size_o = size_q;

endmodule

// File: rtl/rg_resolve.sv
module rg_resolve
    import region_guard_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic [NREG-1:0] hit,
    input  rg_ctrl_t        ctrl [NREG],
    input  logic [1:0]      kind,
    input  logic            priv,
    input  logic            bg_allow,
    output logic            hit_any,
    output logic            allow
);

    rg_ctrl_t win;
    logic     r_ok;
    logic     w_ok;
    logic     x_ok;

    always_comb begin
        win = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) win = ctrl[i];
        end
    end

    assign hit_any = |hit;
    assign r_ok    = priv ? win.pr : win.ur;
    assign w_ok    = priv ? win.pw : win.uw;
    assign x_ok    = priv ? win.px : win.ux;

    always_comb begin
        if (acc_kind_e'(kind) == ACC_RSVD) begin
            allow = 1'b0;
        end else if (!hit_any) begin
            allow = priv && bg_allow;
        end else begin
            unique case (acc_kind_e'(kind))
                ACC_RD:    allow = r_ok;
                ACC_WR:    allow = w_ok;
                ACC_FETCH: allow = x_ok;
                default:   allow = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/rg_fault_fsm.sv
module rg_fault_fsm
    import region_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_in,
    input  logic [AW-1:0] addr_in,
    input  logic          clr,
    output logic          valid_o,
    output logic [AW-1:0] addr_o
);

    flt_state_e    state_q;
    flt_state_e    state_d;
    logic          load;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            FLT_EMPTY: begin
                if (fault_in) begin
                    state_d = FLT_HELD;
                    load    = 1'b1;
                end
            end
            FLT_HELD: begin
                if (clr && fault_in) begin
                    load = 1'b1;
                end else if (clr) begin
                    state_d = FLT_EMPTY;
                end
            end
            default: state_d = FLT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    addr_q <= '0;
        else if (load) addr_q <= addr_in;
    end

    assign valid_o = (state_q == FLT_HELD);
    assign addr_o  = addr_q;

endmodule

// File: rtl/region_guard.sv
module region_guard
    import region_guard_pkg::*;
#(
    parameter int NREG      = 8,
    parameter int AW        = 32,
    parameter int SIZE_MODE = 0,
    localparam int IDXW     = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [IDXW-1:0] cfg_idx,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [1:0]      rd_sel,
    output logic [AW-1:0]   rd_data,
    input  logic            bg_allow,
    input  logic            acc_valid,
    input  logic [AW-1:0]   acc_addr,
    input  logic [1:0]      acc_type,
    input  logic            acc_priv,
    output logic            acc_fault,
    input  logic            flt_clr,
    output logic            flt_valid,
    output logic [AW-1:0]   flt_addr,
    output logic            cfg_err
);

    logic [NREG-1:0] hit;
    logic [NREG-1:0] bad;
    rg_ctrl_t        reg_ctrl [NREG];
    logic [AW-1:0]   reg_base [NREG];
    logic [AW-1:0]   reg_size [NREG];
    logic            hit_any;
    logic            allow;

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            rg_region #(
                .AW        (AW),
                .SIZE_MODE (SIZE_MODE)
            ) u_region (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (cfg_we && (cfg_idx == IDXW'(i))),
                .wr_sel  (cfg_sel),
                .wr_data (cfg_wdata),
                .addr    (acc_addr),
                .hit     (hit[i]),
                .bad     (bad[i]),
                .ctrl_o  (reg_ctrl[i]),
                .base_o  (reg_base[i]),
                .size_o  (reg_size[i])
            );
        end
    endgenerate

    rg_resolve #(
        .NREG (NREG)
    ) u_resolve (
        .hit      (hit),
        .ctrl     (reg_ctrl),
        .kind     (acc_type),
        .priv     (acc_priv),
        .bg_allow (bg_allow),
        .hit_any  (hit_any),
        .allow    (allow)
    );

    assign acc_fault = acc_valid && !allow;
    assign cfg_err   = |bad;

    rg_fault_fsm #(
        .AW (AW)
    ) u_fault (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_in (acc_fault),
        .addr_in  (acc_addr),
        .clr      (flt_clr),
        .valid_o  (flt_valid),
        .addr_o   (flt_addr)
    );

    always_comb begin
        unique case (rd_sel)
            2'd0:    rd_data = reg_base[rd_idx];
            2'd1:    rd_data = reg_size[rd_idx];
            2'd2:    rd_data = {{(AW-CTRL_W){1'b0}}, reg_ctrl[rd_idx]};
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          acc_valid,
    input logic          acc_priv,
    input logic [AW-1:0] acc_addr,
    input logic          acc_fault,
    input logic          hit_any,
    input logic          flt_clr,
    input logic          flt_valid,
    input logic [AW-1:0] flt_addr
);

    a_r3_fault_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        acc_fault |-> acc_valid);

    a_r5_unpriv_miss_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_priv && !hit_any) |-> acc_fault);

    a_r9_first_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!flt_valid && acc_fault) |=> (flt_valid && flt_addr == $past(acc_addr)));

    a_r10_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_clr) |=> (flt_valid && $stable(flt_addr)));

    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_clr && !acc_fault) |=> !flt_valid);

    a_r10_clear_recapture: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_clr && acc_fault) |=> (flt_valid && flt_addr == $past(acc_addr)));

endmodule

bind region_guard region_guard_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_priv  (acc_priv),
    .acc_addr  (acc_addr),
    .acc_fault (acc_fault),
    .hit_any   (hit_any),
    .flt_clr   (flt_clr),
    .flt_valid (flt_valid),
    .flt_addr  (flt_addr)
);

// File: tb/region_guard_test.sv
module region_guard_test;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [1:0]    cfg_sel = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [2:0]    rd_idx = '0;
    logic [1:0]    rd_sel = '0;
    logic          bg_allow = 1'b0;
    logic          acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0]    acc_type = '0;
    logic          acc_priv = 1'b0;
    logic          flt_clr = 1'b0;

    logic [AW-1:0] rd_data, rd_data_g;
    logic          acc_fault, acc_fault_g;
    logic          flt_valid, flt_valid_g;
    logic [AW-1:0] flt_addr, flt_addr_g;
    logic          cfg_err, cfg_err_g;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    region_guard #(.NREG(8), .AW(AW), .SIZE_MODE(0)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
        .rd_sel(rd_sel), .rd_data(rd_data), .bg_allow(bg_allow),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
        .acc_priv(acc_priv), .acc_fault(acc_fault), .flt_clr(flt_clr),
        .flt_valid(flt_valid), .flt_addr(flt_addr), .cfg_err(cfg_err)
    );

    region_guard #(.NREG(8), .AW(AW), .SIZE_MODE(1)) uut_g (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_idx(rd_idx),
        .rd_sel(rd_sel), .rd_data(rd_data_g), .bg_allow(bg_allow),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type),
        .acc_priv(acc_priv), .acc_fault(acc_fault_g), .flt_clr(flt_clr),
        .flt_valid(flt_valid_g), .flt_addr(flt_addr_g), .cfg_err(cfg_err_g)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input int sel, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, input int sel, output logic [AW-1:0] d);
        rd_idx = 3'(idx); rd_sel = 2'(sel);
        #1;
        d = rd_data;
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic [1:0] t, input logic p,
                         input logic clr, output logic f, output logic fg);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_type = t; acc_priv = p; flt_clr = clr;
        #1;
        f = acc_fault; fg = acc_fault_g;
        @(negedge clk);
        acc_valid = 1'b0; flt_clr = 1'b0;
    endtask

    task automatic clear_fault();
        @(negedge clk);
        flt_clr = 1'b1;
        @(negedge clk);
        flt_clr = 1'b0;
    endtask

    task automatic t_reset();
        logic [AW-1:0] d;
        logic f, fg;
        rd(0, 2, d); check("R1 ctrl0", d, 0);
        rd(7, 0, d); check("R1 base7", d, 0);
        rd(7, 1, d); check("R1 size7", d, 0);
        check("R1 flt_valid", AW'(flt_valid), 0);
        check("R1 cfg_err", AW'(cfg_err), 0);
        // R3: invalid cycle never faults
        acc_addr = 32'h1234; acc_priv = 1'b0; #1;
        check("R3 idle no fault", AW'(acc_fault), 0);
        bg_allow = 1'b1;
        probe(32'h100, 2'd0, 1'b1, 1'b0, f, fg); check("R5 priv bg allow", AW'(f), 0);
        probe(32'h104, 2'd1, 1'b0, 1'b0, f, fg); check("R5 unpriv miss", AW'(f), 1);
        bg_allow = 1'b0;
        probe(32'h108, 2'd0, 1'b1, 1'b0, f, fg); check("R5 priv bg deny", AW'(f), 1);
        clear_fault();
    endtask

    task automatic t_perms();
        logic f, fg;
        wr(2, 0, 32'h2000); wr(2, 1, 32'h1000); wr(2, 2, 32'h17);
        probe(32'h2ffc, 2'd0, 1'b1, 1'b0, f, fg); check("R2 priv read", AW'(f), 0);
        probe(32'h2ffc, 2'd1, 1'b1, 1'b0, f, fg); check("R2 priv write", AW'(f), 0);
        probe(32'h2ffc, 2'd2, 1'b1, 1'b0, f, fg); check("R2 priv fetch", AW'(f), 1);
        probe(32'h2000, 2'd0, 1'b0, 1'b0, f, fg); check("R2 unpriv read", AW'(f), 0);
        probe(32'h2000, 2'd1, 1'b0, 1'b0, f, fg); check("R2 unpriv write", AW'(f), 1);
        probe(32'h2000, 2'd2, 1'b0, 1'b0, f, fg); check("R2 unpriv fetch", AW'(f), 1);
        probe(32'h2000, 2'd3, 1'b1, 1'b0, f, fg); check("R2 reserved kind", AW'(f), 1);
        probe(32'h3000, 2'd0, 1'b0, 1'b0, f, fg); check("R2 past limit", AW'(f), 1);
        clear_fault();
    endtask

    task automatic t_priority();
        logic f, fg;
        wr(5, 0, 32'h2800); wr(5, 1, 32'h800); wr(5, 2, 32'h01);
        probe(32'h2900, 2'd0, 1'b1, 1'b0, f, fg); check("R4 higher index denies", AW'(f), 1);
        probe(32'h2100, 2'd0, 1'b1, 1'b0, f, fg); check("R4 outside upper", AW'(f), 0);
        wr(1, 0, 32'h2000); wr(1, 1, 32'h1000); wr(1, 2, 32'h7f);
        probe(32'h2100, 2'd1, 1'b0, 1'b0, f, fg); check("R4 lower index loses", AW'(f), 1);
        clear_fault();
    endtask

    task automatic t_sizing();
        logic f, fg;
        wr(6, 0, 32'h4000); wr(6, 1, 32'h60); wr(6, 2, 32'h7f);
        check("R6 pow2 rejects 0x60", AW'(cfg_err), 1);
        check("R7 granule accepts 0x60", AW'(cfg_err_g), 0);
        probe(32'h4010, 2'd0, 1'b1, 1'b0, f, fg);
        check("R8 illegal region no match", AW'(f), 1);
        check("R7 granule region match", AW'(fg), 0);
        wr(6, 0, 32'h4020); wr(6, 1, 32'h40);
        check("R6 pow2 misaligned base", AW'(cfg_err), 1);
        check("R7 granule aligned base", AW'(cfg_err_g), 0);
        wr(6, 1, 32'h10);
        check("R6 below minimum", AW'(cfg_err), 1);
        check("R7 not granule multiple", AW'(cfg_err_g), 1);
        wr(6, 0, 32'h4040); wr(6, 1, 32'h40);
        check("R8 error clears", AW'(cfg_err), 0);
        check("R8 error clears g", AW'(cfg_err_g), 0);
        probe(32'h407f, 2'd0, 1'b1, 1'b0, f, fg); check("R6 last byte", AW'(f), 0);
        probe(32'h4080, 2'd0, 1'b1, 1'b0, f, fg); check("R6 one past", AW'(f), 1);
        clear_fault();
    endtask

    task automatic t_fault_capture();
        logic f, fg;
        clear_fault();
        check("R10 cleared", AW'(flt_valid), 0);
        probe(32'h2100, 2'd0, 1'b1, 1'b0, f, fg);
        check("R9 allowed no capture", AW'(flt_valid), 0);
        probe(32'h0a00, 2'd0, 1'b0, 1'b0, f, fg);
        check("R9 valid set", AW'(flt_valid), 1);
        check("R9 address", flt_addr, 32'h0a00);
        probe(32'h0b00, 2'd1, 1'b0, 1'b0, f, fg);
        check("R10 keeps first", flt_addr, 32'h0a00);
        probe(32'h2100, 2'd0, 1'b1, 1'b1, f, fg);
        check("R10 clear with allowed access", AW'(flt_valid), 0);
        probe(32'h0c00, 2'd0, 1'b0, 1'b0, f, fg);
        probe(32'h0d00, 2'd2, 1'b0, 1'b1, f, fg);
        check("R10 clear+fault keeps valid", AW'(flt_valid), 1);
        check("R10 clear+fault new address", flt_addr, 32'h0d00);
        clear_fault();
    endtask

    task automatic t_memtype();
        logic [AW-1:0] d;
        logic f, fg;
        wr(2, 2, 32'h117);
        rd(2, 2, d); check("R11 memtype readback", d, 32'h117);
        probe(32'h2100, 2'd1, 1'b1, 1'b0, f, fg); check("R11 priv write same", AW'(f), 0);
        probe(32'h2100, 2'd1, 1'b0, 1'b0, f, fg); check("R11 unpriv write same", AW'(f), 1);
        wr(2, 2, 32'h097);
        rd(2, 2, d); check("R11 device readback", d, 32'h097);
        probe(32'h2100, 2'd0, 1'b0, 1'b0, f, fg); check("R11 unpriv read same", AW'(f), 0);
        clear_fault();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_perms();
        t_priority();
        t_sizing();
        t_fault_capture();
        t_memtype();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule